// File: doc/BRIEF.md
# Secret-Load Forwarding Gate

This block sits in the load-writeback path of an out-of-order core. It decides when the data returned by a speculatively executed load may reach the instructions that depend on it. Every load result arrives with two pieces of side information. The first is a secret bit, taken from the attribute that address translation reports for the page. The second is the tag of the youngest unresolved branch that is older than the load, or a flag saying no such branch exists. The load itself has already executed, because reading secret data does not leak it. Only passing that data on to dependents can leak it.

Results from non-secret pages go straight through, and so do results from loads with no unresolved older branch. Results from secret pages that sit under an unresolved branch wait in a small buffer. An entry leaves the buffer only after its guarding branch resolves as correctly predicted. If that branch or an older one mispredicts, the entry is silently dropped. Released entries go out one per cycle, oldest arrival first. A load that can pass straight through always takes the output ahead of a buffered result. When the buffer is full, a new secret, guarded result is stalled with a low ready rather than being forwarded early.

Branch tags are sequence numbers that wrap. Tag `a` is older than tag `b` when `(b - a) mod 2^BTAG_W` lies between 1 and `2^(BTAG_W-1) - 1`. Branches resolve in program order.

Top module: `secfwd_gate`

## Requirements
- R1: After a synchronous reset, `fwd_vld` is low, `ld_rdy` is high and no result is held.
- R2: An accepted load with `ld_secret` low appears on `fwd_vld`/`fwd_dst`/`fwd_data` after the next clock edge, with its destination tag and data unchanged.
- R3: An accepted load with `ld_secret` high and `ld_guarded` low is forwarded in the same way as R2, with no extra delay.
- R4: An accepted load with both `ld_secret` and `ld_guarded` high is not forwarded until a branch event (`br_vld` high, `br_mispred` low) reports a tag equal to or younger than its guard tag, using the tag order stated above.
- R5: Released entries are forwarded one per cycle in the order in which they arrived. The first goes out on the edge after the one that sampled the releasing branch event. A direct (R2/R3) load in the same cycle takes the output first, and the held entry waits.
- R6: A branch event with `br_mispred` high for tag `t` discards every held, not yet released entry whose guard tag is `t` or younger than `t`. Such an entry is never forwarded.
- R7: A held-type load accepted in the same cycle as a branch event is treated as though it were already buffered. A correct resolve that covers its guard releases it, and it forwards on the following edge. A misprediction that covers its guard drops it.
- R8: The buffer holds `DEPTH` results. While it is full, `ld_rdy` is low only when `ld_secret` and `ld_guarded` are both high. All other loads stay accepted.
- R9: A buffered result leaves with exactly the destination tag and data it arrived with.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_vld | input | 1 | Load result present |
| ld_rdy | output | 1 | Load result accepted this cycle |
| ld_secret | input | 1 | Page attribute: data is secret |
| ld_guarded | input | 1 | An unresolved older branch exists |
| ld_guard_tag | input | BTAG_W | Youngest unresolved older branch |
| ld_dst | input | RTAG_W | Destination register tag |
| ld_data | input | DATA_W | Load data |
| br_vld | input | 1 | Branch resolve event |
| br_mispred | input | 1 | Event is a misprediction |
| br_tag | input | BTAG_W | Tag of the resolved branch |
| fwd_vld | output | 1 | Forward to dependents this cycle |
| fwd_dst | output | RTAG_W | Forwarded destination tag |
| fwd_data | output | DATA_W | Forwarded data |

## Verification
The hardest state to reach is a buffer that holds released entries which cannot leave because direct loads keep taking the output. Some of these entries are interleaved with pending entries under several branch tags, and then a misprediction hits some of them and not others. The random phase keeps a window of up to six unresolved branches, always guards secret loads with the youngest of them, and resolves them in order with an occasional misprediction. Held, released and squashed entries therefore coexist while direct traffic competes for the output. Directed cases first fill the buffer to stall, then release it, squash a subset, and make a load arrive in the same cycle as its own branch event.

// File: rtl/sfg_pkg.sv
package sfg_pkg;
  typedef enum logic [1:0] {
    SRC_NONE   = 2'd0,
    SRC_DIRECT = 2'd1,
    SRC_HELD   = 2'd2
  } fwd_src_e;
endpackage

// File: rtl/sfg_free_pick.sv
module sfg_free_pick #(
  parameter int DEPTH = 8
) (
  input  logic [DEPTH-1:0]         free_mask,
  output logic                     any_free,
  output logic [$clog2(DEPTH)-1:0] free_idx
);
  localparam int IDX_W = $clog2(DEPTH);

  always_comb begin
    any_free = 1'b0;
    free_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (free_mask[i]) begin
        any_free = 1'b1;
        free_idx = i[IDX_W-1:0];
      end
    end
  end
endmodule

// File: rtl/sfg_age_order.sv
module sfg_age_order #(
  parameter int DEPTH = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     alloc_en,
  input  logic [$clog2(DEPTH)-1:0] alloc_idx,
  input  logic [DEPTH-1:0]         valid_mask,
  input  logic [DEPTH-1:0]         req_mask,
  output logic                     grant_any,
  output logic [$clog2(DEPTH)-1:0] grant_idx
);
  localparam int IDX_W = $clog2(DEPTH);

  // row i, bit j set: entry j arrived before entry i
  logic [DEPTH-1:0][DEPTH-1:0] before_q;
  logic [DEPTH-1:0]            win;

  always_ff @(posedge clk) begin
    if (rst) begin
      before_q <= '0;
    end else if (alloc_en) begin
      for (int j = 0; j < DEPTH; j++) begin
        if (j == int'(alloc_idx)) before_q[j] <= valid_mask;
        else                      before_q[j][alloc_idx] <= 1'b0;
      end
    end
  end

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_win
      assign win[i] = req_mask[i] && !(|(req_mask & before_q[i]));
    end
  endgenerate

  always_comb begin
    grant_any = |req_mask;
    grant_idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (win[i]) grant_idx = i[IDX_W-1:0];
    end
  end
endmodule

// File: rtl/secfwd_gate.sv
module secfwd_gate
  import sfg_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  parameter int RTAG_W = 6,
  parameter int BTAG_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_vld,
  output logic              ld_rdy,
  input  logic              ld_secret,
  input  logic              ld_guarded,
  input  logic [BTAG_W-1:0] ld_guard_tag,
  input  logic [RTAG_W-1:0] ld_dst,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              br_vld,
  input  logic              br_mispred,
  input  logic [BTAG_W-1:0] br_tag,
  output logic              fwd_vld,
  output logic [RTAG_W-1:0] fwd_dst,
  output logic [DATA_W-1:0] fwd_data
);
  localparam int IDX_W = $clog2(DEPTH);

  function automatic logic tag_older(input logic [BTAG_W-1:0] a,
                                     input logic [BTAG_W-1:0] b);
    logic [BTAG_W-1:0] d;
    d = b - a;
    return (d != '0) && !d[BTAG_W-1];
  endfunction

  logic [DEPTH-1:0]             vld_q;
  logic [DEPTH-1:0]             rdy_q;
  logic [DEPTH-1:0][BTAG_W-1:0] grd_q;
  logic [DEPTH-1:0][RTAG_W-1:0] dst_q;
  logic [DATA_W-1:0]            mem_q [DEPTH];

  logic             is_direct, full, acc, acc_dir, acc_hold;
  logic             new_kill, new_rel, alloc_en;
  logic             free_any, sel_any;
  logic [IDX_W-1:0] free_idx, sel_idx;
  logic [DEPTH-1:0] kill_vec, rel_vec;
  fwd_src_e         src;

  assign is_direct = !ld_secret || !ld_guarded;
  assign full      = &vld_q;
  assign ld_rdy    = !(full && ld_secret && ld_guarded);
  assign acc       = ld_vld && ld_rdy;
  assign acc_dir   = acc && is_direct;
  assign acc_hold  = acc && !is_direct;
  assign new_kill  = br_vld && br_mispred && !tag_older(ld_guard_tag, br_tag);
  assign new_rel   = br_vld && !br_mispred && !tag_older(br_tag, ld_guard_tag);
  assign alloc_en  = acc_hold && !new_kill && free_any;

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_res
      assign kill_vec[i] = vld_q[i] && !rdy_q[i] && br_vld && br_mispred &&
                           !tag_older(grd_q[i], br_tag);
      assign rel_vec[i]  = vld_q[i] && br_vld && !br_mispred &&
                           !tag_older(br_tag, grd_q[i]);
    end
  endgenerate

  sfg_free_pick #(.DEPTH(DEPTH)) u_free (
    .free_mask (~vld_q),
    .any_free  (free_any),
    .free_idx  (free_idx)
  );

  sfg_age_order #(.DEPTH(DEPTH)) u_age (
    .clk        (clk),
    .rst        (rst),
    .alloc_en   (alloc_en),
    .alloc_idx  (free_idx),
    .valid_mask (vld_q),
    .req_mask   (vld_q & rdy_q),
    .grant_any  (sel_any),
    .grant_idx  (sel_idx)
  );

  always_comb begin
    if (acc_dir)      src = SRC_DIRECT;
    else if (sel_any) src = SRC_HELD;
    else              src = SRC_NONE;
  end

  // entry flags
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
      rdy_q <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (alloc_en && free_idx == i[IDX_W-1:0]) begin
          vld_q[i] <= 1'b1;
          rdy_q[i] <= new_rel;
        end else if ((src == SRC_HELD && sel_idx == i[IDX_W-1:0]) || kill_vec[i]) begin
          vld_q[i] <= 1'b0;
          rdy_q[i] <= 1'b0;
        end else if (rel_vec[i]) begin
          rdy_q[i] <= 1'b1;
        end
      end
    end
  end

  // entry payload, no reset: one write port, one read port
  always_ff @(posedge clk) begin
    if (alloc_en) begin
      mem_q[free_idx] <= ld_data;
      dst_q[free_idx] <= ld_dst;
      grd_q[free_idx] <= ld_guard_tag;
    end
  end

  // registered forward port
  always_ff @(posedge clk) begin
    if (rst) begin
      fwd_vld  <= 1'b0;
      fwd_dst  <= '0;
      fwd_data <= '0;
    end else begin
      fwd_vld <= (src != SRC_NONE);
      if (src == SRC_DIRECT) begin
        fwd_dst  <= ld_dst;
        fwd_data <= ld_data;
      end else if (src == SRC_HELD) begin
        fwd_dst  <= dst_q[sel_idx];
        fwd_data <= mem_q[sel_idx];
      end
    end
  end
endmodule

// File: rtl/secfwd_gate_chk.sv
module secfwd_gate_chk #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  parameter int RTAG_W = 6,
  parameter int BTAG_W = 4
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     ld_vld,
  input logic                     ld_rdy,
  input logic                     ld_secret,
  input logic                     ld_guarded,
  input logic [RTAG_W-1:0]        ld_dst,
  input logic [DATA_W-1:0]        ld_data,
  input logic                     br_vld,
  input logic                     br_mispred,
  input logic [BTAG_W-1:0]        br_tag,
  input logic                     fwd_vld,
  input logic [RTAG_W-1:0]        fwd_dst,
  input logic [DATA_W-1:0]        fwd_data,
  input logic [DEPTH-1:0]         vld_q,
  input logic [DEPTH-1:0]         rdy_q,
  input logic [DEPTH-1:0][BTAG_W-1:0] grd_q
);
  function automatic logic c_older(input logic [BTAG_W-1:0] a,
                                   input logic [BTAG_W-1:0] b);
    logic [BTAG_W-1:0] d;
    d = b - a;
    return (d != '0) && !d[BTAG_W-1];
  endfunction

  p_plain_pass_r2: assert property (@(posedge clk) disable iff (rst)
    (ld_vld && ld_rdy && !ld_secret) |=>
      (fwd_vld && fwd_dst == $past(ld_dst) && fwd_data == $past(ld_data)));

  p_unguarded_pass_r3: assert property (@(posedge clk) disable iff (rst)
    (ld_vld && ld_rdy && ld_secret && !ld_guarded) |=>
      (fwd_vld && fwd_dst == $past(ld_dst) && fwd_data == $past(ld_data)));

  p_quiet_when_empty_r4: assert property (@(posedge clk) disable iff (rst)
    (vld_q == '0 && !(ld_vld && ld_rdy)) |=> !fwd_vld);

  p_drain_one_r5: assert property (@(posedge clk) disable iff (rst)
    !(br_vld && br_mispred) |=>
      ($countones(vld_q) + 1 >= $past($countones(vld_q))));

  p_stall_only_held_r8: assert property (@(posedge clk) disable iff (rst)
    !ld_rdy |-> (ld_secret && ld_guarded && (&vld_q)));

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_sq
      p_squash_r6: assert property (@(posedge clk) disable iff (rst)
        (br_vld && br_mispred && vld_q[i] && !rdy_q[i] &&
         !c_older(grd_q[i], br_tag)) |=> !vld_q[i]);
    end
  endgenerate
endmodule

bind secfwd_gate secfwd_gate_chk #(
  .DEPTH(DEPTH), .DATA_W(DATA_W), .RTAG_W(RTAG_W), .BTAG_W(BTAG_W)
) u_chk (
  .clk(clk), .rst(rst), .ld_vld(ld_vld), .ld_rdy(ld_rdy),
  .ld_secret(ld_secret), .ld_guarded(ld_guarded), .ld_dst(ld_dst),
  .ld_data(ld_data), .br_vld(br_vld), .br_mispred(br_mispred),
  .br_tag(br_tag), .fwd_vld(fwd_vld), .fwd_dst(fwd_dst),
  .fwd_data(fwd_data), .vld_q(vld_q), .rdy_q(rdy_q), .grd_q(grd_q)
);

// File: tb/secfwd_gate_test.sv
module secfwd_gate_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH  = 8;
  localparam int DATA_W = 32;
  localparam int RTAG_W = 6;
  localparam int BTAG_W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ld_vld = 0, ld_secret = 0, ld_guarded = 0;
  logic [BTAG_W-1:0] ld_guard_tag = '0;
  logic [RTAG_W-1:0] ld_dst = '0;
  logic [DATA_W-1:0] ld_data = '0;
  logic br_vld = 0, br_mispred = 0;
  logic [BTAG_W-1:0] br_tag = '0;
  logic ld_rdy, fwd_vld;
  logic [RTAG_W-1:0] fwd_dst;
  logic [DATA_W-1:0] fwd_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  secfwd_gate #(.DEPTH(DEPTH), .DATA_W(DATA_W), .RTAG_W(RTAG_W), .BTAG_W(BTAG_W)) uut (
    .clk(clk), .rst(rst), .ld_vld(ld_vld), .ld_rdy(ld_rdy), .ld_secret(ld_secret),
    .ld_guarded(ld_guarded), .ld_guard_tag(ld_guard_tag), .ld_dst(ld_dst),
    .ld_data(ld_data), .br_vld(br_vld), .br_mispred(br_mispred), .br_tag(br_tag),
    .fwd_vld(fwd_vld), .fwd_dst(fwd_dst), .fwd_data(fwd_data));

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference model of held results
  bit                m_v [DEPTH];
  bit                m_r [DEPTH];
  logic [BTAG_W-1:0] m_g [DEPTH];
  logic [RTAG_W-1:0] m_d [DEPTH];
  logic [DATA_W-1:0] m_x [DEPTH];
  int                m_s [DEPTH];
  int                seq_ctr = 0;

  function automatic bit older(input logic [BTAG_W-1:0] a, input logic [BTAG_W-1:0] b);
    logic [BTAG_W-1:0] d;
    d = b - a;
    return (d != 0) && !d[BTAG_W-1];
  endfunction

  function automatic int held_count();
    int c = 0;
    for (int i = 0; i < DEPTH; i++) c += m_v[i];
    return c;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic drv(input bit v, input bit s, input bit g, input logic [BTAG_W-1:0] gt,
                     input logic [RTAG_W-1:0] d, input logic [DATA_W-1:0] x,
                     input bit bv, input bit bm, input logic [BTAG_W-1:0] bt);
    ld_vld = v; ld_secret = s; ld_guarded = g; ld_guard_tag = gt; ld_dst = d; ld_data = x;
    br_vld = bv; br_mispred = bm; br_tag = bt;
  endtask

  // one clock: check ready, predict, clock, compare
  task automatic step();
    bit exp_rdy, acc, dir, ev, kill;
    logic [RTAG_W-1:0] ed;
    logic [DATA_W-1:0] ex;
    string rq;
    int best;
    #1;
    exp_rdy = !(held_count() == DEPTH && ld_secret && ld_guarded);
    chk(ld_rdy == exp_rdy, "R8", "ld_rdy", ld_rdy, exp_rdy);
    acc = ld_vld && exp_rdy;
    dir = acc && (!ld_secret || !ld_guarded);
    ev = 0; ed = '0; ex = '0; rq = "R4 R6";
    if (dir) begin
      ev = 1; ed = ld_dst; ex = ld_data; rq = ld_secret ? "R3" : "R2";
    end else begin
      best = -1;
      for (int i = 0; i < DEPTH; i++)
        if (m_v[i] && m_r[i] && (best < 0 || m_s[i] < m_s[best])) best = i;
      if (best >= 0) begin
        ev = 1; ed = m_d[best]; ex = m_x[best]; rq = "R5 R9"; m_v[best] = 0;
      end
    end
    for (int i = 0; i < DEPTH; i++) begin
      if (m_v[i] && !m_r[i] && br_vld) begin
        if (br_mispred && !older(m_g[i], br_tag)) m_v[i] = 0;
        else if (!br_mispred && !older(br_tag, m_g[i])) m_r[i] = 1;
      end
    end
    if (acc && !dir) begin
      kill = br_vld && br_mispred && !older(ld_guard_tag, br_tag);
      if (!kill) begin
        for (int i = 0; i < DEPTH; i++) begin
          if (!m_v[i]) begin
            m_v[i] = 1; m_g[i] = ld_guard_tag; m_d[i] = ld_dst; m_x[i] = ld_data;
            m_r[i] = br_vld && !br_mispred && !older(br_tag, ld_guard_tag);
            m_s[i] = seq_ctr++;
            break;
          end
        end
      end
    end
    @(posedge clk); #1;
    chk(fwd_vld == ev, rq, "fwd_vld", fwd_vld, ev);
    if (ev && fwd_vld) begin
      chk(fwd_dst == ed, rq, "fwd_dst", fwd_dst, ed);
      chk(fwd_data == ex, rq, "fwd_data", fwd_data, ex);
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      drv(0, 0, 0, 0, 0, 0, 0, 0, 0);
      step();
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : main
    int unsigned seed;
    logic [BTAG_W-1:0] br_next, br_old;
    int nbr;
    bit bv, bm, lv, ls, lg;
    for (int i = 0; i < DEPTH; i++) m_v[i] = 0;
    seed = 32'd1234;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    #1 rst = 0;
    // R1 reset state
    chk(fwd_vld == 0, "R1", "fwd_vld", fwd_vld, 0);
    chk(ld_rdy == 1, "R1", "ld_rdy", ld_rdy, 1);

    // R2 and R3 direct paths
    drv(1, 0, 1, 4'd1, 6'd3, 32'hA0, 0, 0, 0); step();
    drv(1, 1, 0, 4'd0, 6'd4, 32'hA1, 0, 0, 0); step();
    // R4 fill buffer under branch 1, then R8 stall and bypass
    for (int k = 0; k < DEPTH; k++) begin
      drv(1, 1, 1, 4'd1, 6'(10 + k), 32'hB00 + k, 0, 0, 0); step();
    end
    drv(1, 1, 1, 4'd1, 6'd30, 32'hDEAD, 0, 0, 0); step();
    drv(1, 0, 0, 4'd0, 6'd31, 32'hC0, 0, 0, 0); step();
    idle(2);
    // R5 release all, oldest first
    drv(0, 0, 0, 0, 0, 0, 1, 0, 4'd1); step();
    idle(DEPTH + 1);
    // R6 squash guard 3, keep guard 2
    for (int k = 0; k < 3; k++) begin
      drv(1, 1, 1, 4'd2, 6'(40 + k), 32'hD00 + k, 0, 0, 0); step();
    end
    for (int k = 0; k < 2; k++) begin
      drv(1, 1, 1, 4'd3, 6'(50 + k), 32'hE00 + k, 0, 0, 0); step();
    end
    drv(0, 0, 0, 0, 0, 0, 1, 1, 4'd3); step();
    idle(3);
    drv(0, 0, 0, 0, 0, 0, 1, 0, 4'd2); step();
    idle(5);
    // R7 arrival together with its own branch event
    drv(1, 1, 1, 4'd4, 6'd60, 32'hF0, 1, 0, 4'd4); step();
    drv(1, 1, 1, 4'd5, 6'd61, 32'hF1, 1, 1, 4'd5); step();
    idle(4);

    // random phase
    br_next = 4'd6; br_old = 4'd6; nbr = 0;
    for (int c = 0; c < 4000; c++) begin
      lv = ($urandom % 3) != 0;
      ls = ($urandom % 2) != 0;
      lg = (nbr > 0) && (($urandom % 4) != 0);
      bv = (nbr > 0) && (($urandom % 4) == 0);
      bm = ($urandom % 6) == 0;
      drv(lv, ls, lg, br_next - 4'd1, 6'($urandom), $urandom, bv, bm, br_old);
      step();
      if (bv) begin
        if (bm) begin br_old = br_next; nbr = 0; end
        else begin br_old = br_old + 4'd1; nbr--; end
      end
      if (nbr < 6 && ($urandom % 4) == 0) begin br_next = br_next + 4'd1; nbr++; end
    end
    // resolve anything left and drain
    while (nbr > 0) begin
      drv(0, 0, 0, 0, 0, 0, 1, 0, br_old); step();
      br_old = br_old + 4'd1; nbr--;
    end
    idle(DEPTH + 4);
    chk(held_count() == 0, "R5", "model drained", held_count(), 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule